// File: doc/BRIEF.md
# Event Builder Destination Scheduler

This block decides which event-builder node receives each new event in a readout system. A readout supervisor raises a one-cycle event strobe. One cycle later the scheduler answers with a destination node number and a valid pulse. The readout boards then send that event's fragments to the chosen node. Transport over the network and assembly of the fragments are handled elsewhere.

There are two policies, and a mode input selects between them:

- **Push policy.** The scheduler walks through the nodes in a fixed rotation and ignores the builders completely.
- **Pull policy.** Each builder node posts single-cycle request pulses. Each pulse means "one more event can come here". The scheduler keeps a saturating credit count per node. It only sends an event to a node whose count is above zero, and it rotates among those nodes starting after the node it served last. When no node holds credit in the pull policy, the scheduler raises busy and refuses the event. The supervisor must treat a refused event as dead time and present it again later.

Top module: `evb_dest_sched`

## Requirements
- R1: After reset, `dest_valid` and `busy` are low, every credit count is zero, and the rotation is positioned so that the first served node is node 0.
- R2: With `pull_mode` low, every `event_req` is accepted. `dest_valid` rises in the following cycle. `dest_id` steps 0, 1, …, NODES-1 and then wraps, counting from the last node served in either mode.
- R3: With `pull_mode` low, `busy` stays low and no credit is consumed. Credits posted before or during push operation remain usable after switching to pull.
- R4: A pulse on `node_req[i]` adds one credit to node i. The count saturates at 2^CREDIT_W-1, and further pulses are lost.
- R5: With `pull_mode` high, an event goes only to a node with non-zero credit. The candidate search starts at the node after the last one served and wraps around.
- R6: In pull mode, each assignment to a node removes one of its credits.
- R7: With `pull_mode` high and no node holding credit, `busy` is high in that same cycle. An `event_req` in that cycle produces no `dest_valid`.
- R8: A request and an assignment for the same node in the same cycle leave that node's credit unchanged.
- R9: `dest_valid` is a one-cycle pulse. It appears only in the cycle after an accepted `event_req`.
- R10: A request that arrives in the same cycle as an event cannot be spent on that event. Only credit held before the cycle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pull_mode | input | 1 | 1 = credit-based pull policy, 0 = rotating push policy |
| event_req | input | 1 | One-cycle strobe announcing a new event |
| node_req | input | NODES | Per-node capacity request pulses |
| dest_valid | output | 1 | Pulse: `dest_id` holds the node for the last accepted event |
| dest_id | output | IDW | Chosen builder node number |
| busy | output | 1 | Pull mode with no node holding credit; events are refused |

## Verification
The bound checker enforces several properties on every cycle:

- A refused event never yields a valid output.
- A push-mode or credit-backed event always yields one.
- `busy` never appears in push mode.
- A valid pulse never appears without an event on the previous cycle.
- `dest_id` always stays below NODES.

Some behaviour can only be shown by the bench's scenarios, because it depends on accumulated credit history. This covers:

- the exact rotation order;
- credit saturation;
- the unchanged count when a request and an assignment coincide;
- credits surviving a stretch of push operation.

The bench tracks all of this in its own per-node model.

// File: rtl/evb_dest_sched.sv
module evb_dest_sched #(
  parameter int NODES    = 4,
  parameter int CREDIT_W = 3,
  parameter int IDW      = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pull_mode,
  input  logic             event_req,
  input  logic [NODES-1:0] node_req,
  output logic             dest_valid,
  output logic [IDW-1:0]   dest_id,
  output logic             busy
);
  localparam logic [CREDIT_W-1:0] CMAX = {CREDIT_W{1'b1}};
  localparam logic [IDW-1:0]      LASTN = IDW'(NODES - 1);

  logic [CREDIT_W-1:0] credit [NODES];
  logic [NODES-1:0]    has_cr;
  logic [NODES-1:0]    take;
  logic [IDW-1:0]      last, pick, push_next, gid;
  logic                found, grant;

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NODES; k++) begin
      idx = (int'(last) + k) % NODES;
      if (!found && has_cr[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end

  assign push_next = (last == LASTN) ? '0 : last + 1'b1;
  assign busy      = pull_mode && !found;
  assign grant     = event_req && (!pull_mode || found);
  assign gid       = pull_mode ? pick : push_next;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign has_cr[g] = credit[g] != '0;
    assign take[g]   = grant && pull_mode && (gid == IDW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)
        credit[g] <= '0;
      else if (node_req[g] && !take[g] && credit[g] != CMAX)
        credit[g] <= credit[g] + 1'b1;
      else if (!node_req[g] && take[g])
        credit[g] <= credit[g] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last       <= LASTN;
      dest_valid <= 1'b0;
      dest_id    <= '0;
    end else begin
      dest_valid <= grant;
      if (grant) begin
        last    <= gid;
        dest_id <= gid;
      end
    end
  end
endmodule

module evb_dest_sched_chk #(
  parameter int NODES = 4,
  parameter int IDW   = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pull_mode,
  input logic           event_req,
  input logic           dest_valid,
  input logic [IDW-1:0] dest_id,
  input logic           busy
);
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    event_req && busy |=> !dest_valid); // R7
  AST_PUSH_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    event_req && !pull_mode |=> dest_valid); // R2
  AST_PUSH_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_mode |-> !busy); // R3
  AST_PULL_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
    event_req && pull_mode && !busy |=> dest_valid); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !event_req |=> !dest_valid); // R9
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dest_valid |-> int'(dest_id) < NODES); // R2
endmodule

bind evb_dest_sched evb_dest_sched_chk #(.NODES(NODES), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pull_mode(pull_mode), .event_req(event_req),
  .dest_valid(dest_valid), .dest_id(dest_id), .busy(busy));

// File: tb/evb_dest_sched_test.sv
module evb_dest_sched_test;
  localparam int N    = 4;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;
  localparam int IDW  = 2;

  logic clk = 0, rst_n = 0, pull_mode = 0, event_req = 0;
  logic [N-1:0] node_req = '0;
  logic dest_valid, busy;
  logic [IDW-1:0] dest_id;

  int checks = 0, errors = 0;
  int cr[N];
  int last = N - 1;

  always #2 clk = ~clk;

  evb_dest_sched #(.NODES(N), .CREDIT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .pull_mode(pull_mode), .event_req(event_req),
    .node_req(node_req), .dest_valid(dest_valid), .dest_id(dest_id), .busy(busy));

  function automatic int model_pick();
    for (int k = 1; k <= N; k++) begin
      int idx = (last + k) % N;
      if (cr[idx] > 0) return idx;
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit ev, input bit pm, input logic [N-1:0] rq,
                      input string tag);
    int g;
    bit expv, eb;
    @(negedge clk);
    event_req = ev; pull_mode = pm; node_req = rq;
    #1;
    eb = pm && (model_pick() < 0);
    check(busy == eb, tag, "busy", busy, eb);
    g = pm ? model_pick() : (last + 1) % N;
    expv = ev && (g >= 0);
    for (int i = 0; i < N; i++) begin
      bit tk = expv && pm && (g == i);
      if (rq[i] && !tk) begin
        if (cr[i] < CMAX) cr[i]++;
      end else if (!rq[i] && tk) cr[i]--;
    end
    if (expv) last = g;
    @(posedge clk); #1;
    check(dest_valid == expv, tag, "dest_valid", dest_valid, expv);
    if (expv) check(int'(dest_id) == g, tag, "dest_id", dest_id, g);
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    foreach (cr[i]) cr[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check(dest_valid == 0, "R1", "dest_valid after reset", dest_valid, 0);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    // R2: push rotation from node 0 with wrap
    for (int i = 0; i < 6; i++) step(1, 0, '0, "R2");
    step(0, 0, '0, "R9");
    // R7: pull mode with no credit refuses the event
    step(1, 1, '0, "R7");
    step(1, 1, '0, "R7");
    // R10: a request in the event cycle is not spendable yet
    step(1, 1, 4'b0001, "R10");
    step(1, 1, '0, "R10");
    step(1, 1, '0, "R7");
    // R4: saturation on node 1
    for (int i = 0; i < 10; i++) step(0, 1, 4'b0010, "R4");
    for (int i = 0; i < 9; i++) step(1, 1, '0, "R4");
    // R8: request and assignment to node 3 in the same cycle
    step(0, 1, 4'b1000, "R8");
    step(1, 1, 4'b1000, "R8");
    step(1, 1, '0, "R8");
    step(1, 1, '0, "R8");
    // R3: credits survive push operation
    step(0, 0, 4'b0101, "R3");
    for (int i = 0; i < 5; i++) step(1, 0, '0, "R3");
    // R5 and R6: rotation among credited nodes
    for (int i = 0; i < 4; i++) step(1, 1, '0, "R5");
    // random mixture
    for (int i = 0; i < 4000; i++) begin
      bit ev = ($urandom % 3) != 0;
      bit pm = ($urandom % 5) != 0;
      logic [N-1:0] rq = N'($urandom) & N'($urandom);
      step(ev, pm, rq, pm ? "R6" : "R2");
    end
    @(negedge clk); event_req = 0; node_req = '0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule